// File: doc/BRIEF.md
# Ping-Pong DMA Channel Sequencer

This block is the address-and-count engine of one DMA channel that works through two buffer descriptors in turn. Each descriptor holds a source base address and a byte count. Software loads them through a small register write port. Once the channel is triggered, it issues one read-address request per transfer beat to a memory-side valid/ready interface. Each accepted request moves the address forward by the transfer width and lowers the remaining count.

When one buffer is finished, the channel moves straight on to the other descriptor if software has filled it. Each such hand-over, and each resume from a stall, raises a next-free-buffer interrupt, so software can refill the descriptor that has just been freed. If no filled descriptor is waiting, the channel parks in a STALL state and issues no requests. Software reads back the current state, the buffer index and the interrupt flag through a status register.

Top module: `dbuf_dma_seq`

## Requirements
- R1: After reset the channel is IDLE (state code 0). No request is issued, the interrupt flag is 0, the buffer index is 0, and every register reads back 0.
- R2: The register map, on byte offsets, is as follows. 0x00 is control: bit0 enable, bit1 start (a pulse, not stored), bit2 memory-to-memory mode. 0x04 is status: bit0 interrupt flag, bit1 buffer index, bits3:2 state (0 idle, 1 run, 2 stall). 0x18 and 0x1C are the base addresses of descriptors 0 and 1. 0x20 and 0x24 are their byte counts. The base and count registers read back what was written.
- R3: In IDLE with enable set, peripheral mode (bit2 = 0) triggers the channel at once. Memory-to-memory mode waits until a control write with the start bit set.
- R4: A trigger starts descriptor 0 if its last count write was nonzero, and raises no interrupt. Otherwise the channel enters STALL and issues no request.
- R5: The first request of a buffer carries its base address. Each accepted request (valid and ready) adds XFER_BYTES to the address. While ready is low, valid and the address hold steady.
- R6: A buffer issues ceil(count / XFER_BYTES) requests.
- R7: On the last accept of a buffer, if the other descriptor is filled, the very next request uses that descriptor's base. The buffer index flips and the interrupt flag is set.
- R8: On the last accept with no filled other descriptor, the channel enters STALL. The buffer index then names the other descriptor.
- R9: In STALL, a nonzero count write to the descriptor named by the buffer index resumes RUN on it and sets the interrupt flag. A count write to the other descriptor leaves the channel stalled.
- R10: Writes to the descriptor in use do not change the addresses of the buffer already under way.
- R11: Writing status with bit0 = 1 clears the interrupt flag, and bit0 = 0 has no effect. A new buffer start in the same cycle wins over the clear.
- R12: Clearing enable sends the channel to IDLE at the next accepted request (at once from STALL) and resets the buffer index to 0. It also invalidates both descriptors, so re-enabling with no new count write stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| req_valid | output | 1 | Read-address request valid |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | ADDR_W | Read-address of the request |
| irq_nfb | output | 1 | Next-free-buffer interrupt flag |
| cur_buf | output | 1 | Index of the descriptor in use or awaited |
| chan_state | output | 2 | 0 idle, 1 run, 2 stall |

## Verification
The bench builds the block with ADDR_W = 32, CNT_W = 8 and XFER_BYTES = 4. Short counts of 1, 4, 6, 12 and 16 bytes therefore finish within a few cycles, and the counts that are not a multiple of four exercise the rounding of the final beat. A base just below the top of the 32-bit space shows the address wrapping through zero. Short buffers also let one run cover a two-buffer hand-over, a mid-buffer refill, a stall and resume, and a disable that is held off by a stalled memory side.

// File: rtl/dbuf_dma_pkg.sv
package dbuf_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_STALL = 2'd2
  } chan_state_e;

  localparam int REG_AW = 8;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_STAT  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_BASE0 = 8'h18;
  localparam logic [REG_AW-1:0] OFS_CNT0  = 8'h20;
  localparam logic [REG_AW-1:0] OFS_STEP  = 8'h04;
endpackage

// File: rtl/dbuf_desc_bank.sv
module dbuf_desc_bank
  import dbuf_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [REG_AW-1:0]      wr_addr,
  input  logic [REG_DW-1:0]      wr_data,
  input  logic                   consume,
  input  logic                   consume_idx,
  input  logic                   clear_all,
  output logic [1:0][ADDR_W-1:0] base_o,
  output logic [1:0][CNT_W-1:0]  cnt_o,
  output logic [1:0]             valid_o
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  logic [1:0] cnt_hit;

  for (genvar i = 0; i < 2; i++) begin : g_desc
    localparam logic [REG_AW-1:0] BASE_OFS = OFS_BASE0 + REG_AW'(i) * OFS_STEP;
    localparam logic [REG_AW-1:0] CNT_OFS  = OFS_CNT0 + REG_AW'(i) * OFS_STEP;

    assign cnt_hit[i] = wr_en && (wr_addr == CNT_OFS);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_o[i]  <= '0;
        cnt_o[i]   <= '0;
        valid_o[i] <= 1'b0;
      end else begin
        if (wr_en && (wr_addr == BASE_OFS)) base_o[i] <= wr_data[ADDR_W-1:0];
        if (cnt_hit[i]) begin
          cnt_o[i]   <= wr_data[CNT_W-1:0];
          valid_o[i] <= (wr_data[CNT_W-1:0] != '0);
        end else if (clear_all || (consume && (consume_idx == 1'(i)))) begin
          valid_o[i] <= 1'b0;
        end
      end
    end
  end

  // R12: a disable with no count write leaves both descriptors empty
  a_r12_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_all && !(|cnt_hit)) |=> (valid_o == 2'b00));
endmodule

// File: rtl/dbuf_ctrl_regs.sv
module dbuf_ctrl_regs
  import dbuf_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [REG_AW-1:0]      wr_addr,
  input  logic [REG_DW-1:0]      wr_data,
  input  logic [REG_AW-1:0]      rd_addr,
  input  logic                   buf_start,
  input  chan_state_e            state_i,
  input  logic                   cur_buf_i,
  input  logic [1:0][ADDR_W-1:0] base_i,
  input  logic [1:0][CNT_W-1:0]  cnt_i,
  output logic                   enable_o,
  output logic                   m2m_o,
  output logic                   start_o,
  output logic                   irq_o,
  output logic [REG_DW-1:0]      rd_data
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data[REG_DW-1:3];

  logic ctrl_wr, stat_clr;
  assign ctrl_wr  = wr_en && (wr_addr == OFS_CTRL);
  assign stat_clr = wr_en && (wr_addr == OFS_STAT) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_o <= 1'b0;
      m2m_o    <= 1'b0;
      start_o  <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        enable_o <= wr_data[0];
        m2m_o    <= wr_data[2];
      end
      start_o <= ctrl_wr && wr_data[1];
      if (buf_start)     irq_o <= 1'b1;
      else if (stat_clr) irq_o <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      OFS_CTRL:            rd_data = {29'd0, m2m_o, 1'b0, enable_o};
      OFS_STAT:            rd_data = {28'd0, state_i, cur_buf_i, irq_o};
      OFS_BASE0:           rd_data = 32'(base_i[0]);
      OFS_BASE0 + OFS_STEP: rd_data = 32'(base_i[1]);
      OFS_CNT0:            rd_data = 32'(cnt_i[0]);
      OFS_CNT0 + OFS_STEP: rd_data = 32'(cnt_i[1]);
      default:             rd_data = '0;
    endcase
  end

  // R7/R9: every buffer start leaves the flag raised
  a_r11_irq_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    buf_start |=> irq_o);
  // R11: clear with no start drops the flag
  a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !buf_start) |=> !irq_o);
endmodule

// File: rtl/dbuf_seq.sv
module dbuf_seq
  import dbuf_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int XFER_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable_i,
  input  logic                   m2m_i,
  input  logic                   start_i,
  input  logic [1:0][ADDR_W-1:0] base_i,
  input  logic [1:0][CNT_W-1:0]  cnt_i,
  input  logic [1:0]             valid_i,
  input  logic                   req_ready,
  output logic                   req_valid,
  output logic [ADDR_W-1:0]      req_addr,
  output chan_state_e            state_o,
  output logic                   cur_buf_o,
  output logic                   consume_o,
  output logic                   consume_idx_o,
  output logic                   buf_start_o,
  output logic                   clear_all_o
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(XFER_BYTES);
  localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(XFER_BYTES);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_STEP;
  endfunction
  function automatic logic is_last(input logic [CNT_W-1:0] c);
    return c <= CNT_STEP;
  endfunction
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c);
    return c - CNT_STEP;
  endfunction

  chan_state_e       state_q;
  logic              cur_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;

  logic accept, last_beat, trigger, other, stop, load, load_idx, switch_go, resume_go;

  assign other     = ~cur_q;
  assign accept    = (state_q == ST_RUN) && req_ready;
  assign last_beat = is_last(rem_q);
  assign trigger   = (state_q == ST_IDLE) && enable_i && (!m2m_i || start_i);
  assign stop      = !enable_i && (accept || (state_q == ST_STALL));
  assign switch_go = accept && last_beat && enable_i && valid_i[other];
  assign resume_go = (state_q == ST_STALL) && enable_i && valid_i[cur_q];
  assign load      = (trigger && valid_i[cur_q]) || switch_go || resume_go;
  assign load_idx  = switch_go ? other : cur_q;

  assign buf_start_o   = switch_go || resume_go;
  assign consume_o     = load;
  assign consume_idx_o = load_idx;
  assign clear_all_o   = stop;
  assign req_valid     = (state_q == ST_RUN);
  assign req_addr      = addr_q;
  assign state_o       = state_q;
  assign cur_buf_o     = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
    end else if (stop) begin
      state_q <= ST_IDLE;
      cur_q   <= 1'b0;
    end else if (load) begin
      state_q <= ST_RUN;
      cur_q   <= load_idx;
      addr_q  <= base_i[load_idx];
      rem_q   <= cnt_i[load_idx];
    end else if (trigger) begin
      state_q <= ST_STALL;
    end else if (accept && last_beat) begin
      state_q <= ST_STALL;
      cur_q   <= other;
    end else if (accept) begin
      addr_q <= step_addr(addr_q);
      rem_q  <= step_count(rem_q);
    end
  end

  // R5: a refused request stays put
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));
  // R5: mid-buffer accept moves one beat forward
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !last_beat && enable_i) |=> (req_addr == $past(req_addr) + ADDR_STEP));
  // R8: a stalled channel is silent
  a_r8_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STALL) |-> !req_valid);
  // R7: hand-over flips the buffer index and keeps running
  a_r7_switch: assert property (@(posedge clk) disable iff (!rst_n)
    switch_go |=> (req_valid && (cur_buf_o != $past(cur_buf_o))));
  // R12: disable at a boundary returns to idle on buffer 0
  a_r12_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> ((state_q == ST_IDLE) && !cur_buf_o));
endmodule

// File: rtl/dbuf_dma_seq.sv
module dbuf_dma_seq
  import dbuf_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int XFER_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [7:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              irq_nfb,
  output logic              cur_buf,
  output logic [1:0]        chan_state
);
  logic [1:0][ADDR_W-1:0] base_w;
  logic [1:0][CNT_W-1:0]  cnt_w;
  logic [1:0]             valid_w;
  logic enable_w, m2m_w, start_w;
  logic consume_w, consume_idx_w, buf_start_w, clear_all_w;
  chan_state_e state_w;

  dbuf_desc_bank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .consume(consume_w), .consume_idx(consume_idx_w), .clear_all(clear_all_w),
    .base_o(base_w), .cnt_o(cnt_w), .valid_o(valid_w)
  );

  dbuf_ctrl_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .buf_start(buf_start_w),
    .state_i(state_w), .cur_buf_i(cur_buf),
    .base_i(base_w), .cnt_i(cnt_w),
    .enable_o(enable_w), .m2m_o(m2m_w), .start_o(start_w),
    .irq_o(irq_nfb), .rd_data(rd_data)
  );

  dbuf_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .XFER_BYTES(XFER_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .enable_i(enable_w), .m2m_i(m2m_w), .start_i(start_w),
    .base_i(base_w), .cnt_i(cnt_w), .valid_i(valid_w),
    .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
    .state_o(state_w), .cur_buf_o(cur_buf),
    .consume_o(consume_w), .consume_idx_o(consume_idx_w),
    .buf_start_o(buf_start_w), .clear_all_o(clear_all_w)
  );

  assign chan_state = state_w;
endmodule

// File: tb/test_dbuf_dma_seq.sv
`timescale 1ns/1ps
module test_dbuf_dma_seq;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 8;
  localparam int XFER   = 4;
  localparam int NVEC   = 5;
  // {base, count}
  localparam logic [39:0] VEC [NVEC] = '{
    {32'h0000_1000, 8'd16}, {32'h0000_2000, 8'd6}, {32'h0000_0040, 8'd4},
    {32'h8000_0000, 8'd1},  {32'hFFFF_FFF8, 8'd12}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, req_ready = 1'b1;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic req_valid, irq_nfb, cur_buf;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0] chan_state;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbuf_dma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .XFER_BYTES(XFER)) i_dbuf_dma_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .irq_nfb(irq_nfb), .cur_buf(cur_buf), .chan_state(chan_state)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic wait_run(input string req);
    for (int k = 0; k < 8 && chan_state != 2'd1; k++) tick();
    chk(req, {30'd0, chan_state}, 32'd1);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    logic [31:0] r;
    tick(3);
    // R1 reset state
    chk("R1 state", {30'd0, chan_state}, 32'd0);
    chk("R1 valid", {31'd0, req_valid}, 32'd0);
    chk("R1 irq", {31'd0, irq_nfb}, 32'd0);
    rd(8'h18, r); chk("R1 base0", r, 32'd0);
    rst_n = 1'b1;
    tick();

    // Table walk: single buffers in peripheral mode (R3, R4, R5, R6, R8)
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] b;
      int nreq;
      b = VEC[v][39:8];
      nreq = (int'(VEC[v][7:0]) + XFER - 1) / XFER;
      wr(8'h18, b);
      wr(8'h20, {24'd0, VEC[v][7:0]});
      rd(8'h18, r); chk("R2 base0 readback", r, b);
      wr(8'h00, 32'h1);
      wait_run("R3 periph trigger");
      for (int i = 0; i < nreq; i++) begin
        chk("R5 addr", req_addr, b + 32'(i * XFER));
        tick();
      end
      chk("R6 beats done", {31'd0, req_valid}, 32'd0);
      chk("R8 stall", {30'd0, chan_state}, 32'd2);
      chk("R8 idx", {31'd0, cur_buf}, 32'd1);
      chk("R4 no irq first", {31'd0, irq_nfb}, 32'd0);
      wr(8'h00, 32'h0);
      tick();
      chk("R12 idle", {30'd0, chan_state}, 32'd0);
      chk("R12 idx0", {31'd0, cur_buf}, 32'd0);
    end

    // Ping-pong hand-over (R7, R10, R11)
    wr(8'h18, 32'h100); wr(8'h20, 32'd8);
    wr(8'h1C, 32'h200); wr(8'h24, 32'd16);
    rd(8'h1C, r); chk("R2 base1 readback", r, 32'h200);
    rd(8'h24, r); chk("R2 cnt1 readback", r, 32'd16);
    wr(8'h00, 32'h1);
    wait_run("R3 pingpong");
    chk("R5 a0", req_addr, 32'h100); tick();
    chk("R5 a1", req_addr, 32'h104); tick();
    chk("R7 switch addr", req_addr, 32'h200);
    chk("R7 irq", {31'd0, irq_nfb}, 32'd1);
    chk("R7 idx", {31'd0, cur_buf}, 32'd1);
    wr(8'h1C, 32'h9990);
    chk("R10 active base ignored", req_addr, 32'h204);
    wr(8'h18, 32'h300);
    chk("R10 b2", req_addr, 32'h208);
    wr(8'h20, 32'd4);
    chk("R10 b3", req_addr, 32'h20C);
    wr(8'h04, 32'h1);
    chk("R7 refill switch", req_addr, 32'h300);
    chk("R11 set wins", {31'd0, irq_nfb}, 32'd1);
    chk("R7 idx back", {31'd0, cur_buf}, 32'd0);
    tick();
    chk("R8 stall pp", {30'd0, chan_state}, 32'd2);
    rd(8'h04, r); chk("R2 status", r, 32'h0000_000B);
    wr(8'h04, 32'h0);
    chk("R11 zero no clear", {31'd0, irq_nfb}, 32'd1);
    wr(8'h04, 32'h1);
    chk("R11 w1c", {31'd0, irq_nfb}, 32'd0);

    // R9: write to wrong descriptor does not resume, right one does
    wr(8'h20, 32'd4);
    tick(3);
    chk("R9 other ignored", {30'd0, chan_state}, 32'd2);
    wr(8'h1C, 32'h500); wr(8'h24, 32'd8);
    tick();
    chk("R9 resume", {30'd0, chan_state}, 32'd1);
    chk("R9 resume addr", req_addr, 32'h500);
    chk("R9 irq", {31'd0, irq_nfb}, 32'd1);
    req_ready = 1'b0;
    tick(3);
    chk("R5 hold", req_addr, 32'h500);

    // R12: disable waits for an accept, then invalidates
    wr(8'h00, 32'h0);
    tick();
    chk("R12 wait boundary", {30'd0, chan_state}, 32'd1);
    req_ready = 1'b1;
    tick();
    chk("R12 idle at accept", {30'd0, chan_state}, 32'd0);
    chk("R12 no req", {31'd0, req_valid}, 32'd0);
    wr(8'h00, 32'h1);
    tick();
    chk("R12 invalidated", {30'd0, chan_state}, 32'd2);
    wr(8'h00, 32'h0);
    tick();
    chk("R12 stall exit", {30'd0, chan_state}, 32'd0);

    // R3: memory-to-memory mode waits for start
    wr(8'h18, 32'h700); wr(8'h20, 32'd4);
    wr(8'h00, 32'h5);
    tick(4);
    chk("R3 m2m waits", {30'd0, chan_state}, 32'd0);
    wr(8'h00, 32'h7);
    tick();
    chk("R3 m2m start", {30'd0, chan_state}, 32'd1);
    chk("R3 m2m addr", req_addr, 32'h700);
    tick();
    wr(8'h00, 32'h0);
    tick();

    // R4: zero count stalls, R9 resume on idle descriptor
    wr(8'h18, 32'h900); wr(8'h20, 32'd0);
    wr(8'h00, 32'h1);
    tick();
    chk("R4 zero stall", {30'd0, chan_state}, 32'd2);
    chk("R4 no req", {31'd0, req_valid}, 32'd0);
    wr(8'h20, 32'd8);
    tick();
    chk("R9 resume idx0", req_addr, 32'h900);
    chk("R9 irq idx0", {31'd0, irq_nfb}, 32'd1);
    report();
  end
endmodule